// File: doc/BRIEF.md
# Cellular Array Processing Cell

This block is one processing cell of a two-dimensional grid of identical cells. Every cell receives the same broadcast control word in the same cycle. What each cell does with it depends on the single-bit values arriving from its eight nearest neighbours and on its own ten-bit flag register. The cell drives one output bit, which the surrounding array wiring fans out to all eight neighbours.

On each enabled step the cell gathers a chosen set of inputs through a single OR. The inputs are the eight neighbour lines and the cell's own registered output. Each input can be passed either unconditionally or only when the flag with the same index is set. The OR result can be inverted, and the resulting incident bit is written into any subset of the ten flags. At the same time the cell ANDs a chosen subset of flags and can invert that product. It then ORs the product with an optional bypass copy of the incident bit to form the next output. One flag, number 9, can also be loaded from an external serial input, and its value is always visible on an external serial output.

Top module: `cape_cell`

## Requirements
- R1: While `rst_n` is low all ten flags and `cell_out` are 0, and `ext_out` is 0.
- R2: Control word bits [8:0] select inputs. Bit i (i<8) selects `nbr_in[i]` and bit 8 selects the cell's own `cell_out`. With bit 9 (conditional mode) clear, the OR of the selected inputs forms the incident bit, and selecting no input gives 0.
- R3: With bit 9 set, a selected input i contributes only when flag i is 1.
- R4: Bit 10 set inverts the OR result to give the incident bit.
- R5: On an enabled step, control bits [20:11] (bit 11+i for flag i) load the incident bit into each enabled flag. Flags whose bit is clear keep their value.
- R6: Control bits [31:22] (bit 22+i for flag i) choose flags for the output AND, and an empty choice gives 0. Bit 32 inverts the AND result.
- R7: On an enabled step, `cell_out` takes (output-path result) OR (bit 21 AND incident bit). Flags and output update on the same clock edge, one edge after the inputs are applied, and the incident bit uses the pre-edge flag and output values.
- R8: When `step` is 0, no flag and no output changes, whatever the control word.
- R9: Control bit 33 loads `ext_in` into flag 9 on an enabled step, with priority over that flag's gated write. `ext_out` always shows flag 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Clock enable for the broadcast control word |
| ctrl_word | input | 34 | Broadcast control word (fields as in R2 to R9) |
| nbr_in | input | 8 | Bits from the eight neighbours |
| ext_in | input | 1 | External serial input into flag 9 |
| cell_out | output | 1 | Registered cell output to all neighbours |
| ext_out | output | 1 | External serial output, value of flag 9 |

## Verification
Every result of a step shows up one clock edge after it is applied. The flags and `cell_out` are registered on that edge, and `ext_out` follows flag 9 with no added delay. The bench drives inputs on the falling edge and samples shortly after the next rising edge, comparing against a model that is advanced once per step. Flags have no port of their own. They are read back through the output path one edge later, by selecting a single flag into the AND with bypass and writes disabled. The extra cycle after reset release, added by the synchronizer, is waited out before any step.

// File: rtl/cape_pkg.sv
package cape_pkg;
  localparam int unsigned NBR_N  = 8;
  localparam int unsigned FLAG_N = 10;
  localparam int unsigned IN_N   = NBR_N + 1;
  localparam int unsigned M_IDX  = FLAG_N - 1;

  typedef struct packed {
    logic              m_ext;
    logic              out_inv;
    logic [FLAG_N-1:0] out_sel;
    logic              byp_en;
    logic [FLAG_N-1:0] wr_en;
    logic              in_inv;
    logic              cond;
    logic [IN_N-1:0]   in_sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cape_rst_sync.sv
module cape_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cape_in_gate.sv
module cape_in_gate #(
  parameter int unsigned IN_N = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_N-1:0] in_bits,
  input  logic [IN_N-1:0] in_sel,
  input  logic [IN_N-1:0] cond_flags,
  input  logic            cond,
  input  logic            in_inv,
  output logic            incident
);
  logic [IN_N-1:0] passed;
  logic            or_raw;

  generate
    for (genvar gi = 0; gi < IN_N; gi++) begin : g_gate
      always_comb passed[gi] = in_bits[gi] & in_sel[gi] & (~cond | cond_flags[gi]);
    end
  endgenerate

  always_comb begin
    or_raw   = |passed;
    incident = or_raw ^ in_inv;
  end

  // R2: with nothing selected the OR stays at 0
  p_empty_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sel == '0) |-> !or_raw);
  // R3: in conditional mode inputs whose flag is clear never raise the OR
  p_cond_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond && ((in_sel & cond_flags) == '0)) |-> !or_raw);
endmodule

// File: rtl/cape_flag_reg.sv
module cape_flag_reg #(
  parameter int unsigned FLAG_N = 10,
  parameter int unsigned M_IDX  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FLAG_N-1:0] wr_en,
  input  logic              incident,
  input  logic              m_ext,
  input  logic              ext_in,
  output logic [FLAG_N-1:0] flags
);
  logic [FLAG_N-1:0] flags_q;
  logic [FLAG_N-1:0] flags_d;

  generate
    for (genvar gf = 0; gf < FLAG_N; gf++) begin : g_flag
      if (gf == M_IDX) begin : g_m
        always_comb begin
          flags_d[gf] = flags_q[gf];
          if (step) begin
            if (m_ext)          flags_d[gf] = ext_in;
            else if (wr_en[gf]) flags_d[gf] = incident;
          end
        end
      end else begin : g_plain
        always_comb begin
          flags_d[gf] = flags_q[gf];
          if (step && wr_en[gf]) flags_d[gf] = incident;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R1: flags are clear whenever reset is held
  p_rst_clear_r1: assert property (@(posedge clk) !rst_n |-> (flags_q == '0));
  // R8: no step, no flag change
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(flags_q));
  // R5: flags without write enable (and not externally loaded) keep state
  p_hold_unsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (wr_en == '0) && !m_ext) |=> $stable(flags_q));
  // R9: external load reaches flag M
  p_ext_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && m_ext) |=> (flags_q[M_IDX] == $past(ext_in)));
endmodule

// File: rtl/cape_out_path.sv
module cape_out_path #(
  parameter int unsigned FLAG_N = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FLAG_N-1:0] flags,
  input  logic [FLAG_N-1:0] out_sel,
  input  logic              out_inv,
  input  logic              byp_en,
  input  logic              incident,
  output logic              cell_out
);
  logic and_raw;
  logic out_cmp;
  logic out_d;
  logic out_q;

  always_comb begin
    and_raw = (|out_sel) & (&(flags | ~out_sel));
    out_cmp = and_raw ^ out_inv;
    out_d   = out_q;
    if (step) out_d = out_cmp | (byp_en & incident);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign cell_out = out_q;

  // R6: an empty AND selection yields 0
  p_empty_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == '0) |-> !and_raw);
  // R8: output holds while idle
  p_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out_q));
  // R7: an enabled bypass of a set incident bit forces the output high
  p_byp_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && byp_en && incident) |=> out_q);
  // R1: output cleared under reset
  p_out_rst_r1: assert property (@(posedge clk) !rst_n |-> !out_q);
endmodule

// File: rtl/cape_cell.sv
module cape_cell
  import cape_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [NBR_N-1:0]  nbr_in,
  input  logic              ext_in,
  output logic              cell_out,
  output logic              ext_out
);
  ctrl_t             ctl;
  logic              rst_n_s;
  logic [FLAG_N-1:0] flags;
  logic [IN_N-1:0]   in_bits;
  logic              incident;

  assign ctl     = ctrl_t'(ctrl_word);
  assign in_bits = {cell_out, nbr_in};

  cape_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  cape_in_gate #(.IN_N(IN_N)) u_in (
    .clk(clk), .rst_n(rst_n_s), .in_bits(in_bits), .in_sel(ctl.in_sel),
    .cond_flags(flags[IN_N-1:0]), .cond(ctl.cond), .in_inv(ctl.in_inv),
    .incident(incident)
  );

  cape_flag_reg #(.FLAG_N(FLAG_N), .M_IDX(M_IDX)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .step(step), .wr_en(ctl.wr_en),
    .incident(incident), .m_ext(ctl.m_ext), .ext_in(ext_in), .flags(flags)
  );

  cape_out_path #(.FLAG_N(FLAG_N)) u_out (
    .clk(clk), .rst_n(rst_n_s), .step(step), .flags(flags),
    .out_sel(ctl.out_sel), .out_inv(ctl.out_inv), .byp_en(ctl.byp_en),
    .incident(incident), .cell_out(cell_out)
  );

  assign ext_out = flags[M_IDX];

  // R9: serial output follows flag M after an external load
  p_ext_out_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (step && ctl.m_ext) |=> (ext_out == $past(ext_in)));
endmodule

// File: tb/cape_cell_tb.sv
module cape_cell_tb;
  localparam int CW = 34;
  logic clk = 1'b0;
  logic rst_n, step, ext_in, cell_out, ext_out;
  logic [CW-1:0] ctrl_word;
  logic [7:0] nbr_in;
  int n_chk = 0, n_bad = 0;
  logic [9:0] m_f;
  logic m_o;

  always #2.5 clk = ~clk;

  cape_cell u_dut (.clk(clk), .rst_n(rst_n), .step(step), .ctrl_word(ctrl_word),
    .nbr_in(nbr_in), .ext_in(ext_in), .cell_out(cell_out), .ext_out(ext_out));

  function automatic logic [CW-1:0] mk(input logic [8:0] isel, input logic cnd,
    input logic iinv, input logic [9:0] wr, input logic byp, input logic [9:0] osel,
    input logic oinv, input logic mx);
    return {mx, oinv, osel, byp, wr, iinv, cnd, isel};
  endfunction

  function automatic logic incid(input logic [CW-1:0] c, input logic [7:0] nb);
    logic g = 1'b0;
    for (int i = 0; i < 9; i++) begin
      logic v = (i < 8) ? nb[i] : m_o;
      if (c[i] && (!c[9] || m_f[i])) g = g | v;
    end
    return g ^ c[10];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic [CW-1:0] c, input logic [7:0] nb,
    input logic ex, input logic st, input string tag);
    logic inc, andv, nout;
    logic [9:0] osel, nf;
    @(negedge clk);
    ctrl_word = c; nbr_in = nb; ext_in = ex; step = st;
    inc  = incid(c, nb);
    osel = c[31:22];
    andv = (osel != 0) && ((m_f & osel) == osel);
    nout = (andv ^ c[32]) | (c[21] & inc);
    nf = m_f;
    for (int i = 0; i < 10; i++) if (c[11+i]) nf[i] = inc;
    if (c[33]) nf[9] = ex;
    if (st) begin m_f = nf; m_o = nout; end
    @(posedge clk); #1;
    chk(tag, cell_out, m_o);
    chk(tag, ext_out, m_f[9]);
  endtask

  task automatic read_flag(input int i, input string tag);
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b0, 10'd1 << i, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, tag);
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; ctrl_word = '0; nbr_in = '0; ext_in = 1'b0;
    m_f = '0; m_o = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out", cell_out, 1'b0);
    chk("R1 reset ext", ext_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 10; i++) read_flag(i, "R1 flag readback");
    // R2: each neighbour alone via bypass
    for (int i = 0; i < 8; i++)
      for (int v = 0; v < 2; v++)
        do_step(mk(9'd1 << i, 1'b0, 1'b0, 10'd0, 1'b1, 10'd0, 1'b0, 1'b0),
                8'(v) << i | ~(8'd1 << i) & 8'h00, 1'b0, 1'b1, "R2 single input");
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b1, 10'd0, 1'b0, 1'b0), 8'hFF, 1'b0, 1'b1, "R2 empty OR");
    do_step(mk(9'h0FF, 1'b0, 1'b0, 10'd0, 1'b1, 10'd0, 1'b0, 1'b0), 8'h10, 1'b0, 1'b1, "R2 OR one high");
    do_step(mk(9'h100, 1'b0, 1'b0, 10'd0, 1'b1, 10'd0, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R2 self input");
    // R4: inverted empty OR gives 1, write into all flags
    do_step(mk(9'd0, 1'b0, 1'b1, 10'h3FF, 1'b0, 10'd0, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R4 invert");
    for (int i = 0; i < 10; i++) read_flag(i, "R4 flags set");
    // R5: clear even flags only
    do_step(mk(9'd0, 1'b0, 1'b0, 10'h155, 1'b0, 10'd0, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R5 partial write");
    for (int i = 0; i < 10; i++) read_flag(i, "R5 keep unselected");
    // R3: conditional mode, flags odd set
    for (int i = 0; i < 8; i++)
      do_step(mk(9'd1 << i, 1'b1, 1'b0, 10'd0, 1'b1, 10'd0, 1'b0, 1'b0), 8'hFF, 1'b0, 1'b1, "R3 conditional");
    // R6: AND selections
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b0, 10'h0AA, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R6 AND all set");
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b0, 10'h0AB, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R6 AND one clear");
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b0, 10'h000, 1'b0, 1'b0), 8'h00, 1'b0, 1'b1, "R6 empty AND");
    do_step(mk(9'd0, 1'b0, 1'b0, 10'd0, 1'b0, 10'h000, 1'b1, 1'b0), 8'h00, 1'b0, 1'b1, "R6 inverted empty");
    // R8: no step ignores everything, then readback
    do_step(mk(9'd0, 1'b0, 1'b1, 10'h3FF, 1'b1, 10'd0, 1'b0, 1'b1), 8'hFF, 1'b1, 1'b0, "R8 idle");
    for (int i = 0; i < 10; i++) read_flag(i, "R8 flags held");
    // R9: external load beats gated write
    do_step(mk(9'd0, 1'b0, 1'b1, 10'h200, 1'b0, 10'd0, 1'b0, 1'b1), 8'h00, 1'b0, 1'b1, "R9 ext priority 0");
    do_step(mk(9'd0, 1'b0, 1'b0, 10'h200, 1'b0, 10'd0, 1'b0, 1'b1), 8'h00, 1'b1, 1'b1, "R9 ext priority 1");
    read_flag(9, "R9 flag M");
    // R7: random sweep against model
    for (int k = 0; k < 4000; k++) begin
      logic [CW-1:0] c;
      c = {$urandom, $urandom};
      do_step(c, 8'($urandom), 1'($urandom), ($urandom % 5) != 0, "R7 sweep");
      if (k % 500 == 499)
        for (int i = 0; i < 10; i++) read_flag(i, "R7 sweep readback");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule